// File: doc/BRIEF.md
# Event Counter with Compare Preset

This block is an 8-bit up counter paired with one compare register and an event output that toggles on every compare match. Each count step is chosen from one of three sources: a one-cycle prescaled tick from the system clock domain, a rising edge on an external event input, or prescaled ticks counted only while the external input is high. The external input is synchronised inside the block. Every source becomes a one-cycle count enable on the system clock; none is used as a derived clock.

When the count equals the active compare value, the next count step reloads the counter to 0x01. The same step toggles the event output and raises a compare flag. This lets the block work as a modulus divider or as a periodic interrupt source. A compare value of zero never matches, so the counter runs freely and wraps. Software writes a new compare value into a holding buffer. The buffer moves into the active compare register on the next match or when software writes the counter. A counter write also reloads the count to 0x01.

Top module: `event_count_timer`

## Requirements
- R1: After reset the count is 0x01, the event output is 0, the compare flag is 0 and the interrupt request is 0.
- R2: With `selExt` = 0, each cycle with `preTick` high adds one to the count in the following cycle, and activity on `evtIn` has no effect on the count.
- R3: With `selExt` = 1 and `gateMode` = 0, each rising edge of `evtIn` adds exactly one to the count. The new count is visible three clock edges after the input rises. `preTick` has no effect in this mode.
- R4: With `selExt` = 1 and `gateMode` = 1, a `preTick` cycle adds one only while the synchronised `evtIn` is high. `preTick` cycles with `evtIn` low are ignored.
- R5: A count step taken while the count equals a nonzero active compare value reloads the count to 0x01 instead of incrementing it.
- R6: A `cntWr` strobe reloads the count to 0x01 in the next cycle, takes priority over a count step in the same cycle, and copies the buffered compare value into the active compare register.
- R7: A `cmpWr` strobe stores `cmpData` only in the buffer. The active compare value, and so the point at which the count reloads, stays unchanged until the next match or counter write.
- R8: With an active compare value of 0x00 the counter never matches: it counts up through 0xFF to 0x00 and then to 0x01 without setting the flag.
- R9: `evtOut` inverts on every match reload, so its period is twice the compare value in count steps.
- R10: A match sets `cmpFlag`. `flagClr` clears it, but a match in the same cycle wins. `irq` is high exactly when `cmpFlag` and `irqEn` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 1 | External event input (asynchronous) |
| preTick | input | 1 | One-cycle prescaled clock enable |
| selExt | input | 1 | Count source: 1 external, 0 prescaled |
| gateMode | input | 1 | External mode: 1 gated prescaled ticks, 0 direct edges |
| cntWr | input | 1 | Counter write strobe (reload to 0x01) |
| cmpWr | input | 1 | Compare buffer write strobe |
| cmpData | input | 8 | Compare value to buffer |
| flagClr | input | 1 | Compare flag clear strobe |
| irqEn | input | 1 | Interrupt enable |
| count | output | 8 | Current count |
| evtOut | output | 1 | Event output, toggles per match |
| cmpFlag | output | 1 | Compare match flag |
| irq | output | 1 | Interrupt request |

## Verification
A `preTick`, `cntWr`, `cmpWr` or `flagClr` strobe changes the registered outputs on the first clock edge after it. A rising edge on `evtIn` reaches the count on the third edge, after two synchroniser stages and the edge detector. The bench drives inputs on falling edges and reads outputs on later falling edges. For external events it checks that the count is still unchanged after two edges and has moved after three. `irq` is combinational from the flag and the enable, so it is read a short delay after `irqEn` is driven.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef struct packed {
    logic reload;   // load count with 1
    logic incr;     // count up
    logic xfer;     // buffer -> active compare
  } dpCmd_t;
endpackage

// File: rtl/ect_ctrl.sv
module ect_ctrl
  import ect_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   evtIn,
  input  logic   preTick,
  input  logic   selExt,
  input  logic   gateMode,
  input  logic   cntWr,
  input  logic   flagClr,
  input  logic   matchHit,
  output dpCmd_t cmd,
  output logic   tick,
  output logic   evtOut,
  output logic   cmpFlag
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic evtLvl, evtPrev, extTick, wrap;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= evtIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], evtIn};
    end
  endgenerate

  assign evtLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) evtPrev <= 1'b0;
    else       evtPrev <= evtLvl;

  // gated: prescaled ticks while input high; direct: synchronised rising edge
  assign extTick = gateMode ? (preTick & evtLvl) : (evtLvl & ~evtPrev);
  assign tick    = selExt ? extTick : preTick;
  assign wrap    = tick & matchHit & ~cntWr;

  always_comb begin
    cmd.reload = cntWr | wrap;
    cmd.xfer   = cntWr | wrap;
    cmd.incr   = tick & ~matchHit & ~cntWr;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      evtOut  <= 1'b0;
      cmpFlag <= 1'b0;
    end else begin
      if (wrap) evtOut <= ~evtOut;
      if (wrap)         cmpFlag <= 1'b1;
      else if (flagClr) cmpFlag <= 1'b0;
    end
endmodule

// File: rtl/ect_datapath.sv
module ect_datapath
  import ect_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCmd_t       cmd,
  input  logic         cmpWr,
  input  logic [W-1:0] cmpData,
  output logic [W-1:0] count,
  output logic [W-1:0] cmpAct,
  output logic         matchHit
);
  localparam logic [W-1:0] PRESET = W'(1);
  logic [W-1:0] cmpBuf;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      count  <= PRESET;
      cmpBuf <= '0;
      cmpAct <= '0;
    end else begin
      if (cmd.reload)    count <= PRESET;
      else if (cmd.incr) count <= count + W'(1);
      if (cmd.xfer) cmpAct <= cmpBuf;
      if (cmpWr)    cmpBuf <= cmpData;
    end

  // a zero compare value never matches: free-running mode
  assign matchHit = (cmpAct != '0) && (count == cmpAct);
endmodule

// File: rtl/event_count_timer.sv
module event_count_timer
  import ect_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtIn,
  input  logic         preTick,
  input  logic         selExt,
  input  logic         gateMode,
  input  logic         cntWr,
  input  logic         cmpWr,
  input  logic [W-1:0] cmpData,
  input  logic         flagClr,
  input  logic         irqEn,
  output logic [W-1:0] count,
  output logic         evtOut,
  output logic         cmpFlag,
  output logic         irq
);
  dpCmd_t       cmd;
  logic         tick, matchHit;
  logic [W-1:0] cmpAct;

  ect_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk, .rstN, .evtIn, .preTick, .selExt, .gateMode, .cntWr, .flagClr,
    .matchHit, .cmd, .tick, .evtOut, .cmpFlag
  );

  ect_datapath #(.W(W)) u_dp (
    .clk, .rstN, .cmd, .cmpWr, .cmpData, .count, .cmpAct, .matchHit
  );

  assign irq = cmpFlag & irqEn;
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         tick,
  input logic         matchHit,
  input logic         cntWr,
  input logic         flagClr,
  input logic [W-1:0] count,
  input logic [W-1:0] cmpAct,
  input logic         evtOut,
  input logic         cmpFlag
);
  logic wrap;
  assign wrap = tick && matchHit && !cntWr;

  // R6
  wr_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> count == W'(1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !cntWr) |=> $stable(count));

  // R5
  match_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> count == W'(1));

  // R9
  toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> evtOut != $past(evtOut));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> cmpFlag);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !wrap) |=> !cmpFlag);

  // R8
  free_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpAct == '0 && tick && !cntWr) |=> count == W'($past(count) + W'(1)));
endmodule

bind event_count_timer ect_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .matchHit(matchHit), .cntWr(cntWr),
  .flagClr(flagClr), .count(count), .cmpAct(cmpAct), .evtOut(evtOut),
  .cmpFlag(cmpFlag)
);

// File: tb/tb_event_count_timer.sv
`timescale 1ns/1ps
module tb_event_count_timer;
  logic clk = 1'b0, rstN = 1'b0;
  logic evtIn = 0, preTick = 0, selExt = 0, gateMode = 0;
  logic cntWr = 0, cmpWr = 0, flagClr = 0, irqEn = 0;
  logic [7:0] cmpData = '0;
  logic [7:0] count;
  logic evtOut, cmpFlag, irq;
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  event_count_timer dut (
    .clk, .rstN, .evtIn, .preTick, .selExt, .gateMode, .cntWr, .cmpWr,
    .cmpData, .flagClr, .irqEn, .count, .evtOut, .cmpFlag, .irq
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTick(input int n);
    repeat (n) begin
      @(negedge clk) preTick = 1;
      @(negedge clk) preTick = 0;
    end
  endtask

  task automatic writeCnt();
    @(negedge clk) cntWr = 1;
    @(negedge clk) cntWr = 0;
  endtask

  task automatic writeCmp(input logic [7:0] v);
    @(negedge clk) begin cmpWr = 1; cmpData = v; end
    @(negedge clk) cmpWr = 0;
  endtask

  task automatic clearFlag();
    @(negedge clk) flagClr = 1;
    @(negedge clk) flagClr = 0;
  endtask

  task automatic t_reset();
    idle(1);
    chk("R1 count", count, 1);
    chk("R1 evtOut", evtOut, 0);
    chk("R1 flag", cmpFlag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_internal();
    selExt = 0;
    pulseTick(5);
    chk("R2 five ticks", count, 6);
    @(negedge clk) evtIn = 1;
    idle(4);
    evtIn = 0;
    idle(4);
    chk("R2 evtIn ignored", count, 6);
  endtask

  task automatic t_direct();
    selExt = 1; gateMode = 0;
    idle(3);
    @(negedge clk) evtIn = 1;
    idle(2);
    chk("R3 not yet after two edges", count, 6);
    idle(1);
    chk("R3 counted after three edges", count, 7);
    pulseTick(2);
    chk("R3 preTick ignored, level held", count, 7);
    evtIn = 0;
    idle(3);
    chk("R3 falling edge ignored", count, 7);
  endtask

  task automatic t_gated();
    gateMode = 1;
    pulseTick(2);
    chk("R4 gate low blocks ticks", count, 7);
    @(negedge clk) evtIn = 1;
    idle(3);
    chk("R4 no count without tick", count, 7);
    pulseTick(4);
    chk("R4 gate high passes ticks", count, 11);
    evtIn = 0;
    idle(3);
    selExt = 0;
  endtask

  task automatic t_compare();
    writeCmp(8'd5);
    pulseTick(1);
    chk("R7 buffered value not active", count, 12);
    chk("R7 no flag before transfer", cmpFlag, 0);
    writeCnt();
    chk("R6 counter write reloads", count, 1);
    pulseTick(4);
    chk("R5 count reaches compare", count, 5);
    chk("R10 flag clear before match", cmpFlag, 0);
    pulseTick(1);
    chk("R5 match reloads to one", count, 1);
    chk("R9 evtOut toggled", evtOut, 1);
    chk("R10 flag set", cmpFlag, 1);
    chk("R10 irq masked", irq, 0);
    irqEn = 1; #1;
    chk("R10 irq enabled", irq, 1);
    writeCmp(8'd3);
    pulseTick(4);
    chk("R7 old compare still active", count, 5);
    pulseTick(1);
    chk("R7 reload at old compare", count, 1);
    chk("R9 evtOut toggled back", evtOut, 0);
    pulseTick(2);
    chk("R7 new compare reached", count, 3);
    clearFlag();
    chk("R10 flag cleared", cmpFlag, 0);
    chk("R10 irq cleared", irq, 0);
    @(negedge clk) begin preTick = 1; flagClr = 1; end
    @(negedge clk) begin preTick = 0; flagClr = 0; end
    chk("R5 new compare reloads", count, 1);
    chk("R10 set wins over clear", cmpFlag, 1);
    chk("R9 toggle at new compare", evtOut, 1);
    @(negedge clk) cntWr = 1; preTick = 1;
    @(negedge clk) begin cntWr = 0; preTick = 0; end
    chk("R6 write beats tick", count, 1);
  endtask

  task automatic t_freerun();
    irqEn = 0;
    clearFlag();
    writeCmp(8'd0);
    writeCnt();
    pulseTick(254);
    chk("R8 reaches 0xFF", count, 255);
    pulseTick(1);
    chk("R8 wraps to 0x00", count, 0);
    pulseTick(1);
    chk("R8 continues to 0x01", count, 1);
    chk("R8 no flag", cmpFlag, 0);
    chk("R8 evtOut unchanged", evtOut, 1);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    idle(2);
    rstN = 1;
    t_reset();
    t_internal();
    t_direct();
    t_gated();
    t_compare();
    t_freerun();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule